// File: doc/BRIEF.md
# Half-Word to Word Register Access Bridge

The bridge sits between a master that issues 16-bit transfers and a register block that only accepts 32-bit accesses. It makes a pair of half-word transfers to one word behave as a single atomic word access. On the write side, the lower half is parked in a local buffer and no downstream write is issued for it. The whole word is committed only when the upper half arrives. On the read side, the lower-half access fetches the full word. The low half is returned at once and the high half is parked in a second buffer. A later upper-half read is served from that buffer and never reaches the register block.

Software must therefore write low-then-high and read low-then-high. Full 32-bit transfers bypass both buffers. Byte transfers are rejected and flagged. All downstream signals are combinational from the upstream request, so a downstream strobe appears in the same cycle as the upstream strobe. Read data from the register block is expected in that same cycle.

Top module: `half_word_bridge`

## Requirements
- R1: The access size is given by `s_size_i`: 1 is a half-word and 2 is a word. Upstream half-word address bit 1 (the LSB of `s_addr_i`) selects the half: 0 is the lower half (bits 15:0) and 1 is the upper half (bits 31:16).
- R2: A lower-half write stores `s_wdata_i[15:0]` in the write buffer and issues no downstream access.
- R3: An upper-half write issues exactly one downstream write in the same cycle. Its data is `{s_wdata_i[15:0], write buffer}` and its address is the word address with byte-address bits 1:0 equal to zero.
- R4: A lower-half read issues one downstream read at the word address. It returns `{16'h0, m_rdata_i[15:0]}` and stores `m_rdata_i[31:16]` in the read buffer.
- R5: An upper-half read returns `{16'h0, read buffer}` and issues no downstream access.
- R6: A word access passes straight through: address, write data and read data are unchanged, and neither buffer is modified.
- R7: A request with size code 0 (byte) or 3 is illegal. It issues no downstream access, returns zero read data, leaves both buffers unchanged and asserts `s_err_o` in that cycle only.
- R8: After reset both buffers hold zero.
- R9: `m_req_o` is high only in a cycle where `s_req_i` is high, so each upstream request yields at most one downstream strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_req_i | input | 1 | Upstream request strobe, one cycle per access |
| s_we_i | input | 1 | Upstream write enable |
| s_size_i | input | 2 | Access size code (1 half, 2 word, others illegal) |
| s_addr_i | input | ADDR_W-1 | Upstream half-word address (byte address bits ADDR_W-1:1) |
| s_wdata_i | input | 32 | Upstream write data; half-word uses bits 15:0 |
| s_rdata_o | output | 32 | Upstream read data |
| s_err_o | output | 1 | Illegal-size flag, high in the request cycle |
| m_req_o | output | 1 | Downstream request strobe |
| m_we_o | output | 1 | Downstream write enable |
| m_addr_o | output | ADDR_W | Downstream byte address, bits 1:0 zero |
| m_wdata_o | output | 32 | Downstream write data |
| m_rdata_i | input | 32 | Downstream read data, valid in the request cycle |

## Verification
The assertions assume the register block answers a read in the same cycle it is strobed. They also assume that the upstream size, write enable and address are meaningful only while `s_req_i` is high. The bench models the register block as a small word array that responds combinationally. It changes inputs only at the falling clock edge, so every request is settled before the sampling edge. Random traffic draws all four size codes and scrambles the unused inputs during idle cycles. This way the rejection path and the idle behaviour both stay inside the checked space.

// File: rtl/hwb_pkg.sv
package hwb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic lo_wr;
    logic hi_wr;
    logic lo_rd;
    logic hi_rd;
    logic wd_wr;
    logic wd_rd;
    logic bad;
  } acc_t;
endpackage

// File: rtl/hwb_decode.sv
module hwb_decode
  import hwb_pkg::*;
(
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] size_i,
  input  logic       hi_sel_i,
  output acc_t       acc_o
);
  logic is_half, is_word;

  assign is_half = (size_i == SZ_HALF);
  assign is_word = (size_i == SZ_WORD);

  always_comb begin
    acc_o       = '0;
    acc_o.lo_wr = req_i &  we_i & is_half & ~hi_sel_i;
    acc_o.hi_wr = req_i &  we_i & is_half &  hi_sel_i;
    acc_o.lo_rd = req_i & ~we_i & is_half & ~hi_sel_i;
    acc_o.hi_rd = req_i & ~we_i & is_half &  hi_sel_i;
    acc_o.wd_wr = req_i &  we_i & is_word;
    acc_o.wd_rd = req_i & ~we_i & is_word;
    acc_o.bad   = req_i & ~is_half & ~is_word;
  end
endmodule

// File: rtl/hwb_hold_reg.sv
module hwb_hold_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/half_word_bridge.sv
module half_word_bridge
  import hwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_req_i,
  input  logic              s_we_i,
  input  logic [1:0]        s_size_i,
  input  logic [ADDR_W-1:1] s_addr_i,
  input  logic [DATA_W-1:0] s_wdata_i,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic              s_err_o,
  output logic              m_req_o,
  output logic              m_we_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic [DATA_W-1:0] m_rdata_i
);
  localparam int HALF_W = DATA_W / 2;

  acc_t              acc;
  logic [HALF_W-1:0] wbuf_q, rbuf_q;

  hwb_decode u_dec (
    .req_i    (s_req_i),
    .we_i     (s_we_i),
    .size_i   (s_size_i),
    .hi_sel_i (s_addr_i[1]),
    .acc_o    (acc)
  );

  hwb_hold_reg #(.WIDTH(HALF_W)) u_wbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc.lo_wr),
    .d_i    (s_wdata_i[HALF_W-1:0]),
    .q_o    (wbuf_q)
  );

  hwb_hold_reg #(.WIDTH(HALF_W)) u_rbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc.lo_rd),
    .d_i    (m_rdata_i[DATA_W-1:HALF_W]),
    .q_o    (rbuf_q)
  );

  assign m_req_o   = acc.lo_rd | acc.hi_wr | acc.wd_wr | acc.wd_rd;
  assign m_we_o    = acc.hi_wr | acc.wd_wr;
  assign m_addr_o  = {s_addr_i[ADDR_W-1:2], 2'b00};
  assign m_wdata_o = acc.wd_wr ? s_wdata_i : {s_wdata_i[HALF_W-1:0], wbuf_q};
  assign s_err_o   = acc.bad;

  always_comb begin
    s_rdata_o = '0;
    if (acc.wd_rd)      s_rdata_o = m_rdata_i;
    else if (acc.lo_rd) s_rdata_o = {{HALF_W{1'b0}}, m_rdata_i[HALF_W-1:0]};
    else if (acc.hi_rd) s_rdata_o = {{HALF_W{1'b0}}, rbuf_q};
  end
endmodule

// File: rtl/hwb_checker.sv
module hwb_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              s_req_i,
  input logic              s_we_i,
  input logic [1:0]        s_size_i,
  input logic [ADDR_W-1:1] s_addr_i,
  input logic [DATA_W-1:0] s_wdata_i,
  input logic [DATA_W-1:0] s_rdata_o,
  input logic              s_err_o,
  input logic              m_req_o,
  input logic              m_we_o,
  input logic [ADDR_W-1:0] m_addr_o,
  input logic [DATA_W-1:0] m_wdata_o,
  input logic [DATA_W-1:0] m_rdata_i
);
  localparam int HALF_W = DATA_W / 2;

  logic half, word, bad;
  assign half = s_req_i && s_size_i == 2'd1;
  assign word = s_req_i && s_size_i == 2'd2;
  assign bad  = s_req_i && s_size_i != 2'd1 && s_size_i != 2'd2;

  AST_LO_WR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half && s_we_i && !s_addr_i[1] |-> !m_req_o);  // R2

  AST_HI_WR_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half && s_we_i && s_addr_i[1] |-> m_req_o && m_we_o && m_addr_o[1:0] == 2'b00
      && m_wdata_o[DATA_W-1:HALF_W] == s_wdata_i[HALF_W-1:0]);  // R3

  AST_LO_RD_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half && !s_we_i && !s_addr_i[1] |-> m_req_o && !m_we_o
      && s_rdata_o == {{HALF_W{1'b0}}, m_rdata_i[HALF_W-1:0]});  // R4

  AST_HI_RD_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half && !s_we_i && s_addr_i[1] |-> !m_req_o
      && s_rdata_o[DATA_W-1:HALF_W] == '0);  // R5

  AST_WORD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word |-> m_req_o && m_we_o == s_we_i
      && (s_we_i ? m_wdata_o == s_wdata_i : s_rdata_o == m_rdata_i));  // R6

  AST_BAD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |-> s_err_o && !m_req_o && s_rdata_o == '0);  // R7

  AST_ERR_ONLY_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_err_o |-> bad);  // R7

  AST_NO_SPURIOUS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_req_i |-> !m_req_o && !s_err_o);  // R9
endmodule

bind half_word_bridge hwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .s_req_i   (s_req_i),
  .s_we_i    (s_we_i),
  .s_size_i  (s_size_i),
  .s_addr_i  (s_addr_i),
  .s_wdata_i (s_wdata_i),
  .s_rdata_o (s_rdata_o),
  .s_err_o   (s_err_o),
  .m_req_o   (m_req_o),
  .m_we_o    (m_we_o),
  .m_addr_o  (m_addr_o),
  .m_wdata_o (m_wdata_o),
  .m_rdata_i (m_rdata_i)
);

// File: tb/sim_half_word_bridge.sv
`timescale 1ns/1ps
module sim_half_word_bridge;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_req = 1'b0, s_we = 1'b0;
  logic [1:0]    s_size = 2'd0;
  logic [AW-1:1] s_addr = '0;
  logic [31:0]   s_wdata = '0;
  logic [31:0]   s_rdata;
  logic          s_err, m_req, m_we;
  logic [AW-1:0] m_addr;
  logic [31:0]   m_wdata, m_rdata;

  logic [31:0] ref_mem [0:63];
  logic [15:0] wbuf_e, rbuf_e;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign m_rdata = ref_mem[m_addr[AW-1:2]];

  half_word_bridge #(.ADDR_W(AW), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .s_req_i(s_req), .s_we_i(s_we),
    .s_size_i(s_size), .s_addr_i(s_addr), .s_wdata_i(s_wdata),
    .s_rdata_o(s_rdata), .s_err_o(s_err), .m_req_o(m_req), .m_we_o(m_we),
    .m_addr_o(m_addr), .m_wdata_o(m_wdata), .m_rdata_i(m_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_req(input bit we, input logic [1:0] sz, input bit hi);
    if (sz == 2'd2) return 1'b1;
    if (sz == 2'd1) return we ? hi : !hi;
    return 1'b0;
  endfunction

  // one access in one cycle; checks outputs before the sampling edge
  task automatic access(input bit we, input logic [1:0] sz, input logic [AW-1:0] ba, input logic [31:0] wd);
    logic [31:0] word, exp_rd, exp_wd;
    bit hi, er;
    int idx;
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_size = sz; s_addr = ba[AW-1:1]; s_wdata = wd;
    #1;
    hi = ba[1];
    idx = int'(ba[AW-1:2]);
    word = ref_mem[idx];
    er = (sz != 2'd1 && sz != 2'd2);
    chk(s_err == er, "R7 err flag", 32'(s_err), 32'(er));
    chk(m_req == exp_req(we, sz, hi), "R9/R2/R5 downstream strobe", 32'(m_req), 32'(exp_req(we, sz, hi)));
    if (exp_req(we, sz, hi)) begin
      chk(m_addr == {ba[AW-1:2], 2'b00}, "R3 word address", 32'(m_addr), 32'({ba[AW-1:2], 2'b00}));
      chk(m_we == we, "R6 downstream write enable", 32'(m_we), 32'(we));
    end
    if (we) begin
      exp_wd = (sz == 2'd2) ? wd : {wd[15:0], wbuf_e};
      if (exp_req(we, sz, hi))
        chk(m_wdata == exp_wd, sz == 2'd2 ? "R6 word write data" : "R3 merged write data", m_wdata, exp_wd);
    end else begin
      if (er)            exp_rd = 32'h0;
      else if (sz == 2'd2) exp_rd = word;
      else if (!hi)      exp_rd = {16'h0, word[15:0]};
      else               exp_rd = {16'h0, rbuf_e};
      chk(s_rdata == exp_rd, er ? "R7 read zero" : (sz == 2'd2 ? "R6 word read" : (hi ? "R5 upper read" : "R4 lower read")), s_rdata, exp_rd);
    end
    @(posedge clk);
    if (!er && sz == 2'd1 && !hi) begin
      if (we) wbuf_e = wd[15:0];
      else    rbuf_e = word[31:16];
    end
    if (we && exp_req(we, sz, hi)) ref_mem[idx] = exp_wd;
  endtask

  task automatic idle_cycle(input bit scramble);
    @(negedge clk);
    s_req = 1'b0;
    if (scramble) begin
      s_we = 1'($urandom); s_size = 2'($urandom); s_addr = (AW-1)'($urandom); s_wdata = $urandom;
    end
    #1;
    chk(m_req == 1'b0, "R9 idle no strobe", 32'(m_req), 32'h0);
    chk(s_err == 1'b0, "R7 idle no error", 32'(s_err), 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) ref_mem[i] = $urandom;
    wbuf_e = '0; rbuf_e = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle_cycle(0);
    // R8: both buffers zero after reset
    access(0, 2'd1, 8'h06, 32'h0);
    access(1, 2'd1, 8'h0A, 32'h0000ABCD);
    // R1 R2 R3: low then high write to one word
    access(1, 2'd1, 8'h10, 32'hFFFF1234);
    access(1, 2'd1, 8'h12, 32'h00005678);
    access(0, 2'd2, 8'h10, 32'h0);
    // R4 R5 R6: word read between halves does not disturb read buffer
    access(0, 2'd1, 8'h20, 32'h0);
    access(0, 2'd2, 8'h30, 32'h0);
    access(1, 2'd2, 8'h34, 32'hCAFEF00D);
    access(0, 2'd1, 8'h22, 32'h0);
    // R7: illegal sizes leave buffers alone
    access(1, 2'd1, 8'h40, 32'h00001111);
    access(1, 2'd0, 8'h40, 32'h00002222);
    access(0, 2'd3, 8'h42, 32'h0);
    access(1, 2'd1, 8'h42, 32'h00003333);
    access(0, 2'd1, 8'h40, 32'h0);
    access(0, 2'd0, 8'h40, 32'h0);
    access(1, 2'd2, 8'h44, 32'h12345678);
    access(0, 2'd1, 8'h42, 32'h0);
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 5) == 0) idle_cycle(1);
      else access(1'($urandom), 2'($urandom), AW'($urandom), $urandom);
    end
    idle_cycle(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule